// File: doc/BRIEF.md
# Per-Bank Activation Timing Tracker

This block sits beside an SDRAM command scheduler. It keeps the open or closed state and the open row of each bank, and it judges every command the scheduler offers. Commands arrive on a valid/ready stream. Each accepted command gets a one-bit verdict, legal or illegal, on a response stream one clock later. A legal command updates the bank it targets. An illegal command changes nothing.

Alongside the verdicts, the block drives per-bank ready masks for activation, column access and precharge, so that the scheduler can pick a command that will pass. All spacing rules are counted in clock cycles and set by parameters: row-to-column delay, same-bank activate period, cross-bank activate gap, minimum row-open time and precharge recovery. A column command can request auto-precharge. The bank then closes by itself at the end of the burst, or later if the minimum row-open time has not yet run out.

Back-pressure works only on the response side. The command stream is ready whenever no response is waiting, or when the waiting response is being taken in the same cycle. Bank timers keep running while the stream is stalled.

Top module: `bank_timing_tracker`

## Requirements
- R1: A READ (code 2) or WRITE (code 3) to a bank with no open row is judged illegal. A PRECHARGE (code 4) to a closed bank is also illegal.
- R2: A column command issued in cycle c+T_RCD or later after a legal ACTIVATE (code 1) in cycle c is legal, and one issued earlier is illegal. col_ok bit b shows the same condition for bank b.
- R3: An ACTIVATE to a bank whose row is still open is illegal.
- R4: A second ACTIVATE to the same bank is illegal before cycle c+T_RC, even when the bank has been precharged and has recovered.
- R5: After a legal ACTIVATE in cycle c, any ACTIVATE to another bank is illegal before cycle c+T_RRD. A bank may be activated while other banks hold open rows.
- R6: An explicit PRECHARGE is legal only on an open bank, from cycle c+T_RAS onward. A PRECHARGE accepted in cycle p blocks ACTIVATE to that bank until cycle p+T_RP.
- R7: A column command with cmd_autopre set and burst of n cycles, issued in cycle k, closes the bank in cycle s = max(k+n, c+T_RAS). bank_open drops in cycle s+1 and ACTIVATE is allowed again from s+T_RP. Between the command and s, every command to that bank is illegal.
- R8: An illegal command leaves every bank's state, timers and open row unchanged.
- R9: After reset every bank is closed, every timer is expired and every stored row reads zero. No response is pending.
- R10: cmd_ready equals (not rsp_valid) or rsp_ready. A command accepted at an edge produces rsp_valid and rsp_legal after that edge. These hold steady until rsp_ready is high at an edge.
- R11: NOP (code 0) is always legal and has no effect. Codes 5 to 7 are illegal.
- R12: open_rows bits [b*ROW_W +: ROW_W] hold the row given by the last legal ACTIVATE to bank b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Command code (0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE) |
| cmd_bank | input | BANK_W (2) | Target bank |
| cmd_row | input | ROW_W (12) | Row for ACTIVATE |
| cmd_autopre | input | 1 | Auto-precharge request on a column command |
| cmd_burst | input | BL_W (4) | Burst duration in cycles for auto-precharge (0 treated as 1) |
| rsp_valid | output | 1 | Verdict available |
| rsp_ready | input | 1 | Verdict taken |
| rsp_legal | output | 1 | 1 when the command was legal |
| act_ok | output | NUM_BANKS | ACTIVATE would pass now, per bank |
| col_ok | output | NUM_BANKS | READ/WRITE would pass now, per bank |
| pre_ok | output | NUM_BANKS | PRECHARGE would pass now, per bank |
| bank_open | output | NUM_BANKS | Bank holds a row (including an auto-precharge wait) |
| open_rows | output | NUM_BANKS*ROW_W | Stored row per bank |

## Verification
A verdict is due in the cycle after its command is accepted, so the bench drives each command at a falling edge and reads rsp_legal just after the next rising edge. Bank state and ready masks change one edge after the command that causes them. Each timing bound is therefore probed with a command one cycle before the computed boundary and a command exactly on it. The bench counts those cycles from the ACTIVATE or PRECHARGE cycle, using the parameter values. Auto-precharge closure is observed through bank_open, in the cycle before and the cycle after the predicted close cycle.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4
  } trk_op_e;

  typedef enum logic [1:0] {
    BK_CLOSED  = 2'd0,
    BK_OPEN    = 2'd1,
    BK_AUTOPRE = 2'd2
  } bank_st_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/trk_timer.sv
// Down-counter: load has priority, otherwise counts toward zero and stops.
module trk_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/bank_fsm.sv
// State and spacing timers for one bank.
module bank_fsm
  import bank_trk_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int BL_W  = 4,
  parameter int CNT_W = 4,
  parameter int T_RCD = 3,
  parameter int T_RC  = 9,
  parameter int T_RAS = 6,
  parameter int T_RP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_col,
  input  logic             do_pre,
  input  logic             col_ap,
  input  logic [BL_W-1:0]  col_bl,
  input  logic [ROW_W-1:0] act_row,
  input  logic             rrd_ok,
  output logic             act_ok,
  output logic             col_ok,
  output logic             pre_ok,
  output logic             is_open,
  output logic [ROW_W-1:0] row
);
  localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] LD_RC  = CNT_W'(T_RC - 1);
  localparam logic [CNT_W-1:0] LD_RAS = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);

  bank_st_e        st;
  logic [BL_W-1:0] burst_left;
  logic            rc_exp, rcd_exp, ras_exp, rp_exp;
  logic            ap_fire;
  logic            close_now;

  assign ap_fire   = (st == BK_AUTOPRE) && (burst_left == '0) && ras_exp;
  assign close_now = do_pre || ap_fire;

  trk_timer #(.W(CNT_W)) u_rc  (.clk(clk), .rst_n(rst_n), .load(do_act),
                                .load_val(LD_RC),  .expired(rc_exp));
  trk_timer #(.W(CNT_W)) u_rcd (.clk(clk), .rst_n(rst_n), .load(do_act),
                                .load_val(LD_RCD), .expired(rcd_exp));
  trk_timer #(.W(CNT_W)) u_ras (.clk(clk), .rst_n(rst_n), .load(do_act),
                                .load_val(LD_RAS), .expired(ras_exp));
  trk_timer #(.W(CNT_W)) u_rp  (.clk(clk), .rst_n(rst_n), .load(close_now),
                                .load_val(LD_RP),  .expired(rp_exp));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= BK_CLOSED;
      row <= '0;
    end else begin
      unique case (st)
        BK_CLOSED: if (do_act) begin
          st  <= BK_OPEN;
          row <= act_row;
        end
        BK_OPEN: begin
          if (do_pre)                 st <= BK_CLOSED;
          else if (do_col && col_ap)  st <= BK_AUTOPRE;
        end
        BK_AUTOPRE: if (ap_fire) st <= BK_CLOSED;
        default: st <= BK_CLOSED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      burst_left <= '0;
    else if (do_col && col_ap)
      burst_left <= (col_bl == '0) ? '0 : col_bl - 1'b1;
    else if (st == BK_AUTOPRE && burst_left != '0)
      burst_left <= burst_left - 1'b1;
  end

  assign act_ok  = (st == BK_CLOSED) && rp_exp && rc_exp && rrd_ok;
  assign col_ok  = (st == BK_OPEN) && rcd_exp;
  assign pre_ok  = (st == BK_OPEN) && ras_exp;
  assign is_open = (st != BK_CLOSED);
endmodule

// File: rtl/bank_timing_tracker.sv
module bank_timing_tracker
  import bank_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int BL_W      = 4,
  parameter int T_RCD     = 3,
  parameter int T_RC      = 9,
  parameter int T_RRD     = 2,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 2,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [2:0]                 cmd_op,
  input  logic [BANK_W-1:0]          cmd_bank,
  input  logic [ROW_W-1:0]           cmd_row,
  input  logic                       cmd_autopre,
  input  logic [BL_W-1:0]            cmd_burst,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic                       rsp_legal,
  output logic [NUM_BANKS-1:0]       act_ok,
  output logic [NUM_BANKS-1:0]       col_ok,
  output logic [NUM_BANKS-1:0]       pre_ok,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows
);
  localparam int T_MAX = max2(max2(max2(T_RCD, T_RC), max2(T_RAS, T_RP)), T_RRD);
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam logic [CNT_W-1:0] LD_RRD = CNT_W'(T_RRD - 1);

  logic accept, legal, commit;
  logic is_act, is_col, is_pre;
  logic rrd_exp;

  assign accept = cmd_valid && cmd_ready;
  assign is_act = (cmd_op == OP_ACT);
  assign is_col = (cmd_op == OP_RD) || (cmd_op == OP_WR);
  assign is_pre = (cmd_op == OP_PRE);

  always_comb begin
    unique case (cmd_op)
      OP_NOP:        legal = 1'b1;
      OP_ACT:        legal = act_ok[cmd_bank];
      OP_RD, OP_WR:  legal = col_ok[cmd_bank];
      OP_PRE:        legal = pre_ok[cmd_bank];
      default:       legal = 1'b0;
    endcase
  end

  assign commit = accept && legal;

  // Shared gap between activations of any two banks.
  trk_timer #(.W(CNT_W)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load(commit && is_act),
    .load_val(LD_RRD), .expired(rrd_exp)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = commit && (cmd_bank == BANK_W'(b));

    bank_fsm #(
      .ROW_W(ROW_W), .BL_W(BL_W), .CNT_W(CNT_W),
      .T_RCD(T_RCD), .T_RC(T_RC), .T_RAS(T_RAS), .T_RP(T_RP)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .do_act  (hit && is_act),
      .do_col  (hit && is_col),
      .do_pre  (hit && is_pre),
      .col_ap  (cmd_autopre),
      .col_bl  (cmd_burst),
      .act_row (cmd_row),
      .rrd_ok  (rrd_exp),
      .act_ok  (act_ok[b]),
      .col_ok  (col_ok[b]),
      .pre_ok  (pre_ok[b]),
      .is_open (bank_open[b]),
      .row     (open_rows[b*ROW_W +: ROW_W])
    );
  end

  // One-entry verdict register with back-pressure.
  assign cmd_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_legal <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_legal <= legal;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bank_timing_chk.sv
module bank_timing_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int BANK_W    = 2,
  parameter int T_RRD     = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmd_valid,
  input logic                       cmd_ready,
  input logic [2:0]                 cmd_op,
  input logic [BANK_W-1:0]          cmd_bank,
  input logic                       rsp_valid,
  input logic                       rsp_ready,
  input logic                       rsp_legal,
  input logic [NUM_BANKS-1:0]       act_ok,
  input logic [NUM_BANKS-1:0]       bank_open,
  input logic [NUM_BANKS*ROW_W-1:0] open_rows
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  AST_COL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd_op == 3'd2 || cmd_op == 3'd3) && !bank_open[cmd_bank]) |=> !rsp_legal); // R1

  AST_ACT_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd1 && bank_open[cmd_bank]) |=> !rsp_legal); // R3

  AST_RRD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RRD > 1 && acc && cmd_op == 3'd1 && act_ok[cmd_bank]) |=> (act_ok == '0)); // R5

  AST_ILLEGAL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (rsp_legal || $stable(open_rows))); // R8

  AST_ROW_ONLY_ON_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && cmd_op == 3'd1) |=> $stable(open_rows)); // R12

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_legal))); // R10
endmodule

bind bank_timing_tracker bank_timing_chk #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .BANK_W(BANK_W), .T_RRD(T_RRD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_bank(cmd_bank), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_legal(rsp_legal), .act_ok(act_ok),
  .bank_open(bank_open), .open_rows(open_rows)
);

// File: tb/test_bank_timing_tracker.sv
`timescale 1ns/1ps
module test_bank_timing_tracker;
  localparam int NB = 4;
  localparam int RW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_bank = '0;
  logic [RW-1:0] cmd_row = '0;
  logic cmd_autopre = 1'b0;
  logic [3:0] cmd_burst = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic rsp_legal;
  logic [NB-1:0] act_ok, col_ok, pre_ok, bank_open;
  logic [NB*RW-1:0] open_rows;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bank_timing_tracker i_bank_timing_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_autopre(cmd_autopre), .cmd_burst(cmd_burst), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_legal(rsp_legal), .act_ok(act_ok),
    .col_ok(col_ok), .pre_ok(pre_ok), .bank_open(bank_open), .open_rows(open_rows)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    cmd_valid = 1'b0;
    rsp_ready = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive in the current cycle, return the verdict just after the edge.
  task automatic issue(input logic [2:0] op, input int bank, input logic [RW-1:0] row,
                       input logic ap, input logic [3:0] bl, output logic ok);
    @(negedge clk);
    cmd_op = op; cmd_bank = 2'(bank); cmd_row = row;
    cmd_autopre = ap; cmd_burst = bl; cmd_valid = 1'b1;
    @(posedge clk);
    #1;
    ok = rsp_legal;
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R9 rsp_valid", rsp_valid, 0);
    chk("R9 bank_open", bank_open, 0);
    chk("R9 act_ok", act_ok, 4'hf);
    chk("R9 col_ok", col_ok, 0);
    chk("R9 pre_ok", pre_ok, 0);
    chk("R9 open_rows", open_rows, 0);
    chk("R10 cmd_ready", cmd_ready, 1);
  endtask

  task automatic t_closed_col();
    logic ok;
    do_reset();
    issue(3'd2, 2, 0, 0, 1, ok); chk("R1 read closed", ok, 0);
    issue(3'd3, 1, 0, 0, 1, ok); chk("R1 write closed", ok, 0);
    issue(3'd4, 3, 0, 0, 1, ok); chk("R1 precharge closed", ok, 0);
  endtask

  task automatic t_rcd();
    logic ok;
    do_reset();
    issue(3'd1, 0, 12'h123, 0, 1, ok); chk("R2 act", ok, 1);
    chk("R12 row", open_rows[11:0], 12'h123);
    chk("R2 col_ok early", col_ok[0], 0);
    issue(3'd2, 0, 0, 0, 1, ok); chk("R2 read c+1", ok, 0);
    issue(3'd3, 0, 0, 0, 1, ok); chk("R2 write c+2", ok, 0);
    chk("R2 col_ok at c+3", col_ok[0], 1);
    issue(3'd2, 0, 0, 0, 1, ok); chk("R2 read c+3", ok, 1);
  endtask

  task automatic t_act_open();
    logic ok;
    do_reset();
    issue(3'd1, 1, 12'habc, 0, 1, ok); chk("R3 first act", ok, 1);
    idle(9);
    issue(3'd1, 1, 12'h555, 0, 1, ok); chk("R3 act on open", ok, 0);
    chk("R8 row kept", open_rows[23:12], 12'habc);
    issue(3'd2, 1, 0, 0, 1, ok); chk("R8 bank still open", ok, 1);
  endtask

  task automatic t_rc_rp();
    logic ok;
    do_reset();
    issue(3'd1, 1, 12'h010, 0, 1, ok); chk("R4 act", ok, 1);
    issue(3'd4, 1, 0, 0, 1, ok); chk("R6 pre before ras", ok, 0);
    idle(4);
    issue(3'd4, 1, 0, 0, 1, ok); chk("R6 pre at ras", ok, 1);
    chk("R6 closed", bank_open[1], 0);
    issue(3'd1, 1, 0, 0, 1, ok); chk("R6 act in rp", ok, 0);
    issue(3'd1, 1, 0, 0, 1, ok); chk("R4 act before rc", ok, 0);
    issue(3'd1, 1, 0, 0, 1, ok); chk("R4 act at rc", ok, 1);
    do_reset();
    issue(3'd1, 2, 12'h020, 0, 1, ok); chk("R6 act", ok, 1);
    idle(8);
    issue(3'd4, 2, 0, 0, 1, ok); chk("R6 late pre", ok, 1);
    issue(3'd1, 2, 0, 0, 1, ok); chk("R6 act before rp", ok, 0);
    issue(3'd1, 2, 0, 0, 1, ok); chk("R6 act at rp", ok, 1);
  endtask

  task automatic t_rrd();
    logic ok;
    do_reset();
    issue(3'd1, 0, 12'h001, 0, 1, ok); chk("R5 act b0", ok, 1);
    chk("R5 act_ok gap", act_ok, 0);
    issue(3'd1, 3, 12'h003, 0, 1, ok); chk("R5 act b3 early", ok, 0);
    issue(3'd1, 3, 12'h003, 0, 1, ok); chk("R5 act b3 at rrd", ok, 1);
    issue(3'd2, 0, 0, 0, 1, ok); chk("R5 read b0 while b3 opens", ok, 1);
    issue(3'd1, 2, 12'h002, 0, 1, ok); chk("R5 act b2", ok, 1);
    chk("R12 rows", open_rows, {12'h003, 12'h002, 12'h000, 12'h001});
  endtask

  task automatic t_ap_burst();
    logic ok;
    do_reset();
    issue(3'd1, 0, 12'h044, 0, 1, ok); chk("R7 act", ok, 1);
    idle(2);
    issue(3'd2, 0, 0, 1, 4'd8, ok); chk("R7 read ap", ok, 1);
    issue(3'd2, 0, 0, 0, 1, ok); chk("R7 read during ap", ok, 0);
    issue(3'd4, 0, 0, 0, 1, ok); chk("R7 pre during ap", ok, 0);
    idle(5);
    chk("R7 open before burst end", bank_open[0], 1);
    idle(1);
    chk("R7 closed after burst end", bank_open[0], 0);
    issue(3'd1, 0, 0, 0, 1, ok); chk("R7 act in rp", ok, 0);
    issue(3'd1, 0, 0, 0, 1, ok); chk("R7 act after rp", ok, 1);
  endtask

  task automatic t_ap_ras();
    logic ok;
    do_reset();
    issue(3'd1, 1, 12'h0aa, 0, 1, ok); chk("R7 act", ok, 1);
    idle(2);
    issue(3'd3, 1, 0, 1, 4'd1, ok); chk("R7 write ap", ok, 1);
    idle(1);
    chk("R7 open c+5", bank_open[1], 1);
    idle(1);
    chk("R7 open c+6", bank_open[1], 1);
    idle(1);
    chk("R7 closed c+7", bank_open[1], 0);
  endtask

  task automatic t_codes();
    logic ok;
    do_reset();
    issue(3'd0, 2, 0, 0, 1, ok); chk("R11 nop", ok, 1);
    issue(3'd5, 0, 0, 0, 1, ok); chk("R11 code 5", ok, 0);
    issue(3'd7, 1, 0, 0, 1, ok); chk("R11 code 7", ok, 0);
    chk("R11 no effect", act_ok, 4'hf);
  endtask

  task automatic t_backpressure();
    do_reset();
    @(negedge clk);
    rsp_ready = 1'b0;
    cmd_op = 3'd1; cmd_bank = 2'd0; cmd_row = 12'h0f0; cmd_valid = 1'b1;
    @(posedge clk); #1;
    chk("R10 rsp_valid", rsp_valid, 1);
    chk("R10 rsp_legal", rsp_legal, 1);
    chk("R10 ready low", cmd_ready, 0);
    @(negedge clk);
    cmd_bank = 2'd1;
    @(posedge clk); #1;
    chk("R10 held", {rsp_valid, rsp_legal}, 2'b11);
    chk("R10 stalled cmd ignored", bank_open, 4'b0001);
    @(negedge clk);
    cmd_valid = 1'b0; rsp_ready = 1'b1;
    @(posedge clk); #1;
    chk("R10 drained", rsp_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_closed_col();
    t_rcd();
    t_act_open();
    t_rc_rp();
    t_rrd();
    t_ap_burst();
    t_ap_ras();
    t_codes();
    t_backpressure();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule